// File: doc/BRIEF.md
# Register/Memory Operand Address Unit

This unit turns an operand-addressing byte, an optional scaled-index byte and a displacement word into either a register operand number or a 32-bit memory address. It reads the eight general registers through a flat read bus. It sits in a decode pipeline after the instruction bytes have been gathered: each cycle with `in_valid` high carries one set of operand bytes. One cycle later the result appears on registered outputs.

The unit also reports which operand plays which role. The direction input decides whether the REG-field register is written or read. Index code 100 in the scaled-index byte names no register and contributes nothing to the address. When `strict_mode` is high, that code raises an illegal-encoding flag. Address arithmetic wraps modulo 2^32.

Top module: `modrm_ea_unit`

## Requirements
- R1: The addressing byte is split into MOD in bits [7:6], REG in bits [5:3] and R/M in bits [2:0]. Register numbers 0..7 select, in order, the eax, ecx, edx, ebx, esp, ebp, esi and edi words of `gpr_flat` (word i at bits [32*i+31:32*i]). With MOD=00 and R/M not 100 or 101, the address is the selected register.
- R2: With MOD=11 the operand is a register: `out_is_reg`=1 and `out_addr`=0. With MOD other than 11, `out_is_reg`=0. `out_rm_num` always carries the R/M field and `out_reg_num` always carries the REG field.
- R3: With MOD=01, `disp_word[7:0]` is sign-extended and added to the base. Bits [31:8] of `disp_word` have no effect.
- R4: With MOD=10, the full 32-bit `disp_word` is added to the base.
- R5: MOD=00 with R/M=101 yields an address equal to `disp_word` and uses no register.
- R6: R/M=100 with MOD not 11 uses the scaled-index byte: scale in bits [7:6], index in bits [5:3], base in bits [2:0]. The address is base + index*2^scale + displacement, with the displacement sized by MOD as in R3 and R4 and absent for MOD=00.
- R7: Index code 100 contributes zero to the address.
- R8: Base code 101 with MOD=00 uses no base and adds the full 32-bit `disp_word`. With MOD=01 or 10, base code 101 uses ebp.
- R9: `out_illegal` is 1 exactly when `strict_mode` was high, the scaled-index form was used, and the index code was 100. In every other case it is 0.
- R10: `out_reg_is_dest` equals the direction bit. 1 means REG is the destination and R/M the source; 0 means REG is the source and R/M the destination.
- R11: Address sums wrap modulo 2^32.
- R12: `out_valid` follows `in_valid` by exactly one cycle. When `in_valid` is low, all other outputs hold their values. After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand bytes present this cycle |
| strict_mode | input | 1 | Flag index code 100 as illegal |
| dir_bit | input | 1 | Direction bit of the opcode |
| modrm_byte | input | 8 | Addressing byte (MOD, REG, R/M) |
| sib_byte | input | 8 | Scaled-index byte (scale, index, base) |
| disp_word | input | 32 | Displacement; low byte only for MOD=01 |
| gpr_flat | input | 256 | Eight general registers, register i in word i |
| out_valid | output | 1 | Result valid |
| out_is_reg | output | 1 | Operand is a register, not memory |
| out_rm_num | output | 3 | R/M field |
| out_reg_num | output | 3 | REG field |
| out_reg_is_dest | output | 1 | REG operand is the destination |
| out_addr | output | 32 | Effective address (0 for register form) |
| out_illegal | output | 1 | Undefined encoding under strict mode |

## Verification
A mistaken decode shows up on `out_addr` or `out_illegal` in the cycle after the offending input. Typical mistakes are picking the wrong base, applying the index code 100 as a register, or sizing the displacement wrongly. Every output is compared with a behavioural model on every clock, so a fault appears one cycle after the input that exposes it. The special slots for base 101 and R/M 101 are exercised on their own. A register whose load enable is wrong shows during idle cycles, as an output that changes when it should hold.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int unsigned FIELD_W = 3;

  typedef enum logic [1:0] {
    DISP_NONE = 2'd0,
    DISP_BYTE = 2'd1,
    DISP_WORD = 2'd2
  } disp_kind_e;

  typedef struct packed {
    logic               base_en;
    logic [FIELD_W-1:0] base_sel;
    logic               idx_en;
    logic [FIELD_W-1:0] idx_sel;
    logic [1:0]         scale;
    disp_kind_e         disp_kind;
    logic               is_reg;
    logic               bad_index;
  } ea_ctrl_t;
endpackage

// File: rtl/ea_decode.sv
module ea_decode
  import ea_pkg::*;
(
  input  logic [1:0]         mode,
  input  logic [FIELD_W-1:0] rm,
  input  logic [7:0]         sib,
  output ea_ctrl_t           ctrl
);
  localparam logic [FIELD_W-1:0] CODE_SIB  = 3'd4;
  localparam logic [FIELD_W-1:0] CODE_NOBR = 3'd5;

  logic [FIELD_W-1:0] sib_base;
  logic [FIELD_W-1:0] sib_idx;

  assign sib_base = sib[2:0];
  assign sib_idx  = sib[5:3];

  always_comb begin
    ctrl           = '0;
    ctrl.disp_kind = DISP_NONE;
    if (mode == 2'b11) begin
      ctrl.is_reg = 1'b1;
    end else if (rm == CODE_SIB) begin
      ctrl.base_sel  = sib_base;
      ctrl.base_en   = !((mode == 2'b00) && (sib_base == CODE_NOBR));
      ctrl.idx_sel   = sib_idx;
      ctrl.idx_en    = (sib_idx != CODE_SIB);
      ctrl.bad_index = (sib_idx == CODE_SIB);
      ctrl.scale     = sib[7:6];
      unique case (mode)
        2'b00:   ctrl.disp_kind = ctrl.base_en ? DISP_NONE : DISP_WORD;
        2'b01:   ctrl.disp_kind = DISP_BYTE;
        default: ctrl.disp_kind = DISP_WORD;
      endcase
    end else if ((mode == 2'b00) && (rm == CODE_NOBR)) begin
      ctrl.disp_kind = DISP_WORD;
    end else begin
      ctrl.base_en  = 1'b1;
      ctrl.base_sel = rm;
      unique case (mode)
        2'b00:   ctrl.disp_kind = DISP_NONE;
        2'b01:   ctrl.disp_kind = DISP_BYTE;
        default: ctrl.disp_kind = DISP_WORD;
      endcase
    end
  end
endmodule

// File: rtl/ea_sum.sv
module ea_sum
  import ea_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NREG   = 8
) (
  input  logic [NREG*DATA_W-1:0] gpr_flat,
  input  logic                   base_en,
  input  logic [FIELD_W-1:0]     base_sel,
  input  logic                   idx_en,
  input  logic [FIELD_W-1:0]     idx_sel,
  input  logic [1:0]             scale,
  input  disp_kind_e             disp_kind,
  input  logic [DATA_W-1:0]      disp,
  output logic [DATA_W-1:0]      addr
);
  logic [DATA_W-1:0] regs [NREG];
  logic [DATA_W-1:0] base_val;
  logic [DATA_W-1:0] idx_val;
  logic [DATA_W-1:0] disp_val;

  for (genvar g = 0; g < NREG; g++) begin : g_unpack
    assign regs[g] = gpr_flat[g*DATA_W +: DATA_W];
  end

  always_comb begin
    base_val = base_en ? regs[base_sel] : '0;
    idx_val  = idx_en ? (regs[idx_sel] << scale) : '0;
    unique case (disp_kind)
      DISP_BYTE: disp_val = {{(DATA_W-8){disp[7]}}, disp[7:0]};
      DISP_WORD: disp_val = disp;
      default:   disp_val = '0;
    endcase
    addr = base_val + idx_val + disp_val;
  end
endmodule

// File: rtl/ea_outreg.sv
module ea_outreg
  import ea_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               d_is_reg,
  input  logic [FIELD_W-1:0] d_rm,
  input  logic [FIELD_W-1:0] d_reg,
  input  logic               d_dest,
  input  logic [DATA_W-1:0]  d_addr,
  input  logic               d_illegal,
  output logic               q_valid,
  output logic               q_is_reg,
  output logic [FIELD_W-1:0] q_rm,
  output logic [FIELD_W-1:0] q_reg,
  output logic               q_dest,
  output logic [DATA_W-1:0]  q_addr,
  output logic               q_illegal
);
  logic               n_is_reg, n_dest, n_illegal;
  logic [FIELD_W-1:0] n_rm, n_reg;
  logic [DATA_W-1:0]  n_addr;

  always_comb begin
    n_is_reg  = q_is_reg;
    n_rm      = q_rm;
    n_reg     = q_reg;
    n_dest    = q_dest;
    n_addr    = q_addr;
    n_illegal = q_illegal;
    if (in_valid) begin
      n_is_reg  = d_is_reg;
      n_rm      = d_rm;
      n_reg     = d_reg;
      n_dest    = d_dest;
      n_addr    = d_is_reg ? '0 : d_addr;
      n_illegal = d_illegal;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid   <= 1'b0;
      q_is_reg  <= 1'b0;
      q_rm      <= '0;
      q_reg     <= '0;
      q_dest    <= 1'b0;
      q_addr    <= '0;
      q_illegal <= 1'b0;
    end else begin
      q_valid   <= in_valid;
      q_is_reg  <= n_is_reg;
      q_rm      <= n_rm;
      q_reg     <= n_reg;
      q_dest    <= n_dest;
      q_addr    <= n_addr;
      q_illegal <= n_illegal;
    end
  end

  // R12: data outputs hold when no new operand arrives
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(q_addr) && $stable(q_illegal) && $stable(q_is_reg));
endmodule

// File: rtl/modrm_ea_unit.sv
module modrm_ea_unit
  import ea_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NREG   = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic                   strict_mode,
  input  logic                   dir_bit,
  input  logic [7:0]             modrm_byte,
  input  logic [7:0]             sib_byte,
  input  logic [DATA_W-1:0]      disp_word,
  input  logic [NREG*DATA_W-1:0] gpr_flat,
  output logic                   out_valid,
  output logic                   out_is_reg,
  output logic [FIELD_W-1:0]     out_rm_num,
  output logic [FIELD_W-1:0]     out_reg_num,
  output logic                   out_reg_is_dest,
  output logic [DATA_W-1:0]      out_addr,
  output logic                   out_illegal
);
  ea_ctrl_t          ctrl;
  logic [DATA_W-1:0] sum_addr;

  ea_decode u_dec (
    .mode (modrm_byte[7:6]),
    .rm   (modrm_byte[2:0]),
    .sib  (sib_byte),
    .ctrl (ctrl)
  );

  ea_sum #(.DATA_W(DATA_W), .NREG(NREG)) u_sum (
    .gpr_flat  (gpr_flat),
    .base_en   (ctrl.base_en),
    .base_sel  (ctrl.base_sel),
    .idx_en    (ctrl.idx_en),
    .idx_sel   (ctrl.idx_sel),
    .scale     (ctrl.scale),
    .disp_kind (ctrl.disp_kind),
    .disp      (disp_word),
    .addr      (sum_addr)
  );

  ea_outreg #(.DATA_W(DATA_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .d_is_reg  (ctrl.is_reg),
    .d_rm      (modrm_byte[2:0]),
    .d_reg     (modrm_byte[5:3]),
    .d_dest    (dir_bit),
    .d_addr    (sum_addr),
    .d_illegal (strict_mode & ctrl.bad_index),
    .q_valid   (out_valid),
    .q_is_reg  (out_is_reg),
    .q_rm      (out_rm_num),
    .q_reg     (out_reg_num),
    .q_dest    (out_reg_is_dest),
    .q_addr    (out_addr),
    .q_illegal (out_illegal)
  );

  a_r12_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r12_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r2_reg_form: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && modrm_byte[7:6] == 2'b11) |=> (out_is_reg && out_addr == '0));
  a_r5_disp_only: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && modrm_byte[7:6] == 2'b00 && modrm_byte[2:0] == 3'd5)
      |=> (out_addr == $past(disp_word) && !out_is_reg));
  a_r9_lenient: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !strict_mode) |=> !out_illegal);
  a_r10_roles: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_reg_is_dest == $past(dir_bit)));
endmodule

// File: tb/modrm_ea_unit_bench.sv
`timescale 1ns/1ps
module modrm_ea_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, strict_mode, dir_bit;
  logic [7:0]  modrm_byte, sib_byte;
  logic [31:0] disp_word;
  logic [255:0] gpr_flat;
  logic        out_valid, out_is_reg, out_reg_is_dest, out_illegal;
  logic [2:0]  out_rm_num, out_reg_num;
  logic [31:0] out_addr;

  logic [31:0] gpr [8];
  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // expected outputs
  logic        e_valid, e_is_reg, e_dest, e_ill;
  logic [2:0]  e_rm, e_reg;
  logic [31:0] e_addr;
  string       e_tag;

  always #2 clk = ~clk;

  always_comb
    for (int i = 0; i < 8; i++) gpr_flat[i*32 +: 32] = gpr[i];

  modrm_ea_unit u_modrm_ea_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .strict_mode(strict_mode),
    .dir_bit(dir_bit), .modrm_byte(modrm_byte), .sib_byte(sib_byte),
    .disp_word(disp_word), .gpr_flat(gpr_flat), .out_valid(out_valid),
    .out_is_reg(out_is_reg), .out_rm_num(out_rm_num), .out_reg_num(out_reg_num),
    .out_reg_is_dest(out_reg_is_dest), .out_addr(out_addr), .out_illegal(out_illegal)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(out_valid == e_valid, "R12", "valid", out_valid, e_valid);
    chk(out_is_reg == e_is_reg, "R2", "is_reg", out_is_reg, e_is_reg);
    chk(out_rm_num == e_rm, "R2", "rm_num", out_rm_num, e_rm);
    chk(out_reg_num == e_reg, "R2", "reg_num", out_reg_num, e_reg);
    chk(out_reg_is_dest == e_dest, "R10", "reg_is_dest", out_reg_is_dest, e_dest);
    chk(out_illegal == e_ill, "R9", "illegal", out_illegal, e_ill);
    chk(out_addr == e_addr, e_tag, "addr", out_addr, e_addr);
  endtask

  function automatic logic [31:0] model_addr(input logic [7:0] m, input logic [7:0] s,
                                             input logic [31:0] d, output string tag);
    int md = int'(m[7:6]);
    int rm = int'(m[2:0]);
    int bs = int'(s[2:0]);
    int ix = int'(s[5:3]);
    int sc = int'(s[7:6]);
    longint acc = 0;
    longint dterm = 0;
    if (md == 1) dterm = longint'($signed(d[7:0]));
    else if (md == 2) dterm = longint'(d);
    if (md == 3) begin
      tag = "R2";
      return 32'd0;
    end
    if (rm == 4) begin
      tag = (ix == 4) ? "R7" : ((bs == 5) ? "R8" : "R6");
      if (ix != 4) acc += longint'(gpr[ix]) * (longint'(1) << sc);
      if (bs == 5 && md == 0) acc += longint'(d);
      else acc += longint'(gpr[bs]);
      acc += dterm;
    end else if (md == 0 && rm == 5) begin
      tag = "R5";
      acc = longint'(d);
    end else begin
      tag = (md == 1) ? "R3" : ((md == 2) ? "R4" : "R1");
      acc = longint'(gpr[rm]) + dterm;
    end
    return acc[31:0];
  endfunction

  task automatic apply(input bit v, input bit st, input bit dr,
                       input logic [7:0] m, input logic [7:0] s, input logic [31:0] d);
    string t;
    logic [31:0] a;
    @(negedge clk);
    compare();
    in_valid = v; strict_mode = st; dir_bit = dr;
    modrm_byte = m; sib_byte = s; disp_word = d;
    e_valid = v;
    if (v) begin
      a = model_addr(m, s, d, t);
      e_addr = a; e_tag = t;
      e_is_reg = (m[7:6] == 2'b11);
      e_rm = m[2:0]; e_reg = m[5:3]; e_dest = dr;
      e_ill = st && (m[7:6] != 2'b11) && (m[2:0] == 3'd4) && (s[5:3] == 3'd4);
    end
  endtask

  initial begin
    #400000;
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    gpr[0] = 32'h0000_1000; gpr[1] = 32'h0002_0000; gpr[2] = 32'h0030_0000;
    gpr[3] = 32'h0400_0000; gpr[4] = 32'h5000_0000; gpr[5] = 32'h0600_0000;
    gpr[6] = 32'h0070_0000; gpr[7] = 32'h0008_0000;
    rst_n = 1'b0; in_valid = 0; strict_mode = 0; dir_bit = 0;
    modrm_byte = 0; sib_byte = 0; disp_word = 0;
    e_valid = 0; e_is_reg = 0; e_dest = 0; e_ill = 0; e_rm = 0; e_reg = 0;
    e_addr = 0; e_tag = "R12";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state (R12) is checked by the first compare
    apply(1, 0, 0, 8'h00, 8'h00, 32'h0);          // R1 [eax]
    apply(1, 0, 1, 8'hC1, 8'h00, 32'hDEAD);       // R2 register ecx, d=1 R10
    apply(1, 0, 0, 8'h46, 8'h00, 32'h1234_5680);  // R3 esi-128, upper bits ignored
    apply(1, 0, 1, 8'h47, 8'h00, 32'hFFFF_FF7F);  // R3 edi+127
    apply(1, 0, 0, 8'h87, 8'h00, 32'h8000_0001);  // R4 edi+disp32
    apply(1, 0, 0, 8'h05, 8'h00, 32'hCAFE_0000);  // R5 disp only
    apply(1, 0, 0, 8'h04, 8'h88, 32'h0);          // R6 eax+ecx*4
    apply(1, 0, 0, 8'h04, 8'hD3, 32'hFFFF);       // R6 ebx+edx*8, no disp
    apply(1, 1, 0, 8'h04, 8'hE5, 32'h0000_4444);  // R8 disp32, R7 index ignored, R9 strict
    apply(1, 0, 0, 8'h04, 8'hE5, 32'h0000_4444);  // R9 lenient
    apply(1, 0, 0, 8'h44, 8'h25, 32'h0000_00F0);  // R8 ebp-16, R7
    apply(1, 1, 1, 8'h84, 8'h75, 32'h0000_0100);  // R8 ebp+esi*2+disp32
    apply(0, 1, 0, 8'hFF, 8'hFF, 32'hFFFF_FFFF);  // R12 hold
    apply(0, 0, 1, 8'h05, 8'h00, 32'h1);          // R12 hold
    gpr[7] = 32'hFFFF_FFF0;
    apply(1, 0, 0, 8'h87, 8'h00, 32'h0000_0020);  // R11 wrap to 0x10
    apply(1, 0, 0, 8'h04, 8'hFF, 32'h0);          // R11 edi*8+edi wraps
    for (int k = 0; k < 400; k++) begin
      logic [31:0] r = $urandom;
      if (k % 50 == 0) gpr[k % 8] = $urandom;
      apply(r[0] | r[1], r[2], r[3], 8'($urandom), 8'($urandom), $urandom);
    end
    apply(0, 0, 0, 8'h00, 8'h00, 32'h0);
    @(negedge clk);
    compare();
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule